// File: doc/BRIEF.md
# Per-Core Local Interrupt Router

This block sits beside a cluster of processor cores and turns a set of raw interrupt lines into one normal interrupt (IRQ) and one fast interrupt (FIQ) per core. Each core has four private timer lines and four mailbox lines. The router also receives one interrupt shared by the whole cluster, which it sends to a chosen core, and one performance-monitor line per core. Software programs per-core enable words and the routing fields over a simple word-wide register bus. It reads back two status words per core: one shows every source now raised as IRQ, the other every source now raised as FIQ.

Each source can be steered to IRQ or to FIQ. When both are enabled, FIQ wins, so a source never shows up on both outputs of a core. The status bits are plain levels and follow their sources. Nothing is latched, so clearing an interrupt is done at the source. The eight outputs and the read data are registered for clean timing at the cluster boundary.

Top module: `core_irq_router`

## Requirements
- R1: After a synchronous active-high reset, all enable words, the shared routing field and both performance-monitor masks read as zero, and every `irq` and `fiq` output is low.
- R2: The timer control word of core n is at byte offset 0x40+4n. Bits [3:0] enable timer lines 0..3 as IRQ and bits [7:4] enable them as FIQ. A raised timer line k shows in pending bit k.
- R3: When a source's FIQ enable is set, that source appears only in the FIQ-pending word and never in the IRQ-pending word, whatever its IRQ enable holds.
- R4: The mailbox control word of core n is at 0x50+4n, with IRQ enables in bits [3:0] and FIQ enables in bits [7:4]. Mailbox line k shows in pending bit 4+k.
- R5: The IRQ-pending word of core n reads at 0x60+4n and the FIQ-pending word at 0x70+4n. Bit 8 is the shared interrupt and bit 9 is the performance monitor. Bits follow their sources with no latching, and writes to these offsets change nothing.
- R6: Output `irq[n]` is the OR of core n's IRQ-pending bits and `fiq[n]` the OR of its FIQ-pending bits, each registered, so each output changes one clock edge after its cause.
- R7: The routing word at 0x0C holds the core index that takes the shared interrupt as IRQ in bits [1:0] and the one that takes it as FIQ in bits [3:2]. If both name the same core, that core receives it as FIQ only.
- R8: Writing ones at 0x10 sets performance-monitor enables (bits [3:0] IRQ per core, bits [7:4] FIQ per core). Writing ones at 0x14 clears them. Zero bits leave the mask alone, and both offsets read back the current mask in that layout.
- R9: Read data appears on `bus_rdata` one clock edge after the address, and any offset not listed above reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe, one word per cycle |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data for the previous cycle's address |
| timer_src | input | 4*NCORES | Timer lines, four per core, core n at [4n+3:4n] |
| mbox_src | input | 4*NCORES | Mailbox lines, four per core, core n at [4n+3:4n] |
| shared_src | input | 1 | Cluster-wide shared interrupt line |
| perf_src | input | NCORES | Performance-monitor line of each core |
| irq | output | NCORES | Registered normal interrupt per core |
| fiq | output | NCORES | Registered fast interrupt per core |

## Verification
The bench uses the defaults: NCORES=4, ADDR_W=8, DATA_W=32. With four cores the 2-bit routing fields use every index value, including the highest core. Each per-core address block is then filled up to its last word (0x4C, 0x5C, 0x6C, 0x7C), so an off-by-one in the per-core decode shows up as a wrong core answering. The 32-bit data width lets the bench write all-ones patterns and confirm that unused upper bits neither reach a register nor come back on a read.

// File: rtl/core_irq_router_pkg.sv
package core_irq_router_pkg;

  // fixed source counts per core and pending-word layout
  localparam int unsigned NTMR    = 4;
  localparam int unsigned NMBX    = 4;
  localparam int unsigned PEND_W  = NTMR + NMBX + 2;
  localparam int unsigned TMR_LSB = 0;
  localparam int unsigned MBX_LSB = NTMR;
  localparam int unsigned BIT_SHR = NTMR + NMBX;
  localparam int unsigned BIT_PRF = NTMR + NMBX + 1;

  // byte offsets of the register map
  localparam int unsigned OFS_ROUTE = 'h0C;
  localparam int unsigned OFS_PSET  = 'h10;
  localparam int unsigned OFS_PCLR  = 'h14;
  localparam int unsigned OFS_TMR   = 'h40;
  localparam int unsigned OFS_MBX   = 'h50;
  localparam int unsigned OFS_IPND  = 'h60;
  localparam int unsigned OFS_FPND  = 'h70;
  localparam int unsigned WORD_B    = 4;

  // an enable word: FIQ enables above IRQ enables
  typedef struct packed {
    logic [3:0] fen;
    logic [3:0] ien;
  } ctl_t;

  // steering of a group of level sources with FIQ taking priority
  function automatic logic [3:0] grp_fiq(input logic [3:0] src, input ctl_t c);
    return src & c.fen;
  endfunction

  function automatic logic [3:0] grp_irq(input logic [3:0] src, input ctl_t c);
    return src & c.ien & ~c.fen;
  endfunction

endpackage

// File: rtl/cir_regs.sv
module cir_regs
  import core_irq_router_pkg::*;
#(
  parameter int unsigned NCORES = 4,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CIDX_W = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    bus_we,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic [DATA_W-1:0]       bus_wdata,
  output ctl_t [NCORES-1:0]       tmr_ctl,
  output ctl_t [NCORES-1:0]       mbx_ctl,
  output logic [2*CIDX_W-1:0]     shared_route,
  output logic [NCORES-1:0]       pmu_ien,
  output logic [NCORES-1:0]       pmu_fen
);

  localparam logic [ADDR_W-1:0] A_ROUTE = ADDR_W'(OFS_ROUTE);
  localparam logic [ADDR_W-1:0] A_PSET  = ADDR_W'(OFS_PSET);
  localparam logic [ADDR_W-1:0] A_PCLR  = ADDR_W'(OFS_PCLR);

  logic wr_route, wr_pset, wr_pclr;
  logic [NCORES-1:0] wr_tmr, wr_mbx;

  assign wr_route = bus_we && (bus_addr == A_ROUTE);
  assign wr_pset  = bus_we && (bus_addr == A_PSET);
  assign wr_pclr  = bus_we && (bus_addr == A_PCLR);

  // per-core word decode
  for (genvar c = 0; c < NCORES; c++) begin : g_dec
    localparam logic [ADDR_W-1:0] A_T = ADDR_W'(OFS_TMR + WORD_B * c);
    localparam logic [ADDR_W-1:0] A_M = ADDR_W'(OFS_MBX + WORD_B * c);
    assign wr_tmr[c] = bus_we && (bus_addr == A_T);
    assign wr_mbx[c] = bus_we && (bus_addr == A_M);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tmr_ctl <= '0;
      mbx_ctl <= '0;
    end else begin
      for (int c = 0; c < NCORES; c++) begin
        if (wr_tmr[c]) tmr_ctl[c] <= ctl_t'(bus_wdata[7:0]);
        if (wr_mbx[c]) mbx_ctl[c] <= ctl_t'(bus_wdata[7:0]);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shared_route <= '0;
    end else if (wr_route) begin
      shared_route <= bus_wdata[2*CIDX_W-1:0];
    end
  end

  // set and clear live at different offsets, so they never collide
  always_ff @(posedge clk) begin
    if (rst) begin
      pmu_ien <= '0;
      pmu_fen <= '0;
    end else if (wr_pset) begin
      pmu_ien <= pmu_ien | bus_wdata[NCORES-1:0];
      pmu_fen <= pmu_fen | bus_wdata[4 +: NCORES];
    end else if (wr_pclr) begin
      pmu_ien <= pmu_ien & ~bus_wdata[NCORES-1:0];
      pmu_fen <= pmu_fen & ~bus_wdata[4 +: NCORES];
    end
  end

endmodule

// File: rtl/cir_steer.sv
module cir_steer
  import core_irq_router_pkg::*;
#(
  parameter int unsigned CORE_ID = 0,
  parameter int unsigned CIDX_W  = 2
) (
  input  ctl_t                tctl,
  input  ctl_t                mctl,
  input  logic [NTMR-1:0]     tsrc,
  input  logic [NMBX-1:0]     msrc,
  input  logic                shared_src,
  input  logic [2*CIDX_W-1:0] shared_route,
  input  logic                psrc,
  input  logic                pien,
  input  logic                pfen,
  output logic [PEND_W-1:0]   ipend,
  output logic [PEND_W-1:0]   fpend
);

  localparam logic [CIDX_W-1:0] ME = CIDX_W'(CORE_ID);

  logic hit_irq, hit_fiq;

  assign hit_irq = (shared_route[CIDX_W-1:0] == ME);
  assign hit_fiq = (shared_route[2*CIDX_W-1:CIDX_W] == ME);

  always_comb begin
    ipend = '0;
    fpend = '0;
    ipend[TMR_LSB +: NTMR] = grp_irq(tsrc, tctl);
    fpend[TMR_LSB +: NTMR] = grp_fiq(tsrc, tctl);
    ipend[MBX_LSB +: NMBX] = grp_irq(msrc, mctl);
    fpend[MBX_LSB +: NMBX] = grp_fiq(msrc, mctl);
    fpend[BIT_SHR] = shared_src & hit_fiq;
    ipend[BIT_SHR] = shared_src & hit_irq & ~hit_fiq;
    fpend[BIT_PRF] = psrc & pfen;
    ipend[BIT_PRF] = psrc & pien & ~pfen;
  end

endmodule

// File: rtl/cir_readmux.sv
module cir_readmux
  import core_irq_router_pkg::*;
#(
  parameter int unsigned NCORES = 4,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CIDX_W = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  ctl_t [NCORES-1:0]        tmr_ctl,
  input  ctl_t [NCORES-1:0]        mbx_ctl,
  input  logic [2*CIDX_W-1:0]      shared_route,
  input  logic [NCORES-1:0]        pmu_ien,
  input  logic [NCORES-1:0]        pmu_fen,
  input  logic [NCORES*PEND_W-1:0] ip_flat,
  input  logic [NCORES*PEND_W-1:0] fp_flat,
  output logic [DATA_W-1:0]        bus_rdata
);

  logic [DATA_W-1:0] rd_nxt;
  logic [7:0]        pmu_word;

  always_comb begin
    pmu_word = '0;
    pmu_word[NCORES-1:0]   = pmu_ien;
    pmu_word[4 +: NCORES]  = pmu_fen;
  end

  always_comb begin
    rd_nxt = '0;
    if (bus_addr == ADDR_W'(OFS_ROUTE)) rd_nxt = DATA_W'(shared_route);
    if (bus_addr == ADDR_W'(OFS_PSET) || bus_addr == ADDR_W'(OFS_PCLR))
      rd_nxt = DATA_W'(pmu_word);
    for (int c = 0; c < NCORES; c++) begin
      if (bus_addr == ADDR_W'(OFS_TMR + WORD_B * c)) rd_nxt = DATA_W'(tmr_ctl[c]);
      if (bus_addr == ADDR_W'(OFS_MBX + WORD_B * c)) rd_nxt = DATA_W'(mbx_ctl[c]);
      if (bus_addr == ADDR_W'(OFS_IPND + WORD_B * c))
        rd_nxt = DATA_W'(ip_flat[c*PEND_W +: PEND_W]);
      if (bus_addr == ADDR_W'(OFS_FPND + WORD_B * c))
        rd_nxt = DATA_W'(fp_flat[c*PEND_W +: PEND_W]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_nxt;
  end

endmodule

// File: rtl/core_irq_router.sv
module core_irq_router
  import core_irq_router_pkg::*;
#(
  parameter int unsigned NCORES = 4,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   bus_we,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic [DATA_W-1:0]      bus_wdata,
  output logic [DATA_W-1:0]      bus_rdata,
  input  logic [NCORES*NTMR-1:0] timer_src,
  input  logic [NCORES*NMBX-1:0] mbox_src,
  input  logic                   shared_src,
  input  logic [NCORES-1:0]      perf_src,
  output logic [NCORES-1:0]      irq,
  output logic [NCORES-1:0]      fiq
);

  localparam int unsigned CIDX_W = (NCORES > 1) ? $clog2(NCORES) : 1;

  ctl_t [NCORES-1:0]        tmr_ctl;
  ctl_t [NCORES-1:0]        mbx_ctl;
  logic [2*CIDX_W-1:0]      shared_route;
  logic [NCORES-1:0]        pmu_ien;
  logic [NCORES-1:0]        pmu_fen;
  logic [NCORES*PEND_W-1:0] ip_flat;
  logic [NCORES*PEND_W-1:0] fp_flat;

  cir_regs #(
    .NCORES(NCORES), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CIDX_W(CIDX_W)
  ) u_regs (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .tmr_ctl(tmr_ctl), .mbx_ctl(mbx_ctl),
    .shared_route(shared_route), .pmu_ien(pmu_ien), .pmu_fen(pmu_fen)
  );

  for (genvar c = 0; c < NCORES; c++) begin : g_core
    cir_steer #(.CORE_ID(c), .CIDX_W(CIDX_W)) u_steer (
      .tctl(tmr_ctl[c]),
      .mctl(mbx_ctl[c]),
      .tsrc(timer_src[c*NTMR +: NTMR]),
      .msrc(mbox_src[c*NMBX +: NMBX]),
      .shared_src(shared_src),
      .shared_route(shared_route),
      .psrc(perf_src[c]),
      .pien(pmu_ien[c]),
      .pfen(pmu_fen[c]),
      .ipend(ip_flat[c*PEND_W +: PEND_W]),
      .fpend(fp_flat[c*PEND_W +: PEND_W])
    );

    always_ff @(posedge clk) begin
      if (rst) begin
        irq[c] <= 1'b0;
        fiq[c] <= 1'b0;
      end else begin
        irq[c] <= |ip_flat[c*PEND_W +: PEND_W];
        fiq[c] <= |fp_flat[c*PEND_W +: PEND_W];
      end
    end
  end

  cir_readmux #(
    .NCORES(NCORES), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CIDX_W(CIDX_W)
  ) u_rd (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .tmr_ctl(tmr_ctl),
    .mbx_ctl(mbx_ctl), .shared_route(shared_route), .pmu_ien(pmu_ien),
    .pmu_fen(pmu_fen), .ip_flat(ip_flat), .fp_flat(fp_flat),
    .bus_rdata(bus_rdata)
  );

endmodule

// File: rtl/core_irq_router_chk.sv
module core_irq_router_chk
  import core_irq_router_pkg::*;
#(
  parameter int unsigned NCORES = 4,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CIDX_W = 2
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     bus_we,
  input logic [ADDR_W-1:0]        bus_addr,
  input logic [DATA_W-1:0]        bus_wdata,
  input logic [NCORES-1:0]        irq,
  input logic [NCORES-1:0]        fiq,
  input logic [NCORES*PEND_W-1:0] ip_flat,
  input logic [NCORES*PEND_W-1:0] fp_flat,
  input logic [2*CIDX_W-1:0]      shared_route,
  input logic [NCORES-1:0]        pmu_ien
);

  logic [NCORES-1:0] shr_irq_cores, shr_fiq_cores, any_ip, any_fp;

  for (genvar c = 0; c < NCORES; c++) begin : g_gather
    assign shr_irq_cores[c] = ip_flat[c*PEND_W + BIT_SHR];
    assign shr_fiq_cores[c] = fp_flat[c*PEND_W + BIT_SHR];
    assign any_ip[c]        = |ip_flat[c*PEND_W +: PEND_W];
    assign any_fp[c]        = |fp_flat[c*PEND_W +: PEND_W];
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (irq == '0) && (fiq == '0));

  // R3
  fiq_excludes_irq_chk: assert property (@(posedge clk) disable iff (rst)
    (ip_flat & fp_flat) == '0);

  // R6
  out_tracks_pend_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (irq == $past(any_ip)) && (fiq == $past(any_fp)));

  // R7
  shared_single_core_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(shr_irq_cores) && $onehot0(shr_fiq_cores));

  // R7
  route_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(bus_we && bus_addr == ADDR_W'(OFS_ROUTE)) |=> $stable(shared_route));

  // R8
  pmu_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == ADDR_W'(OFS_PCLR))
      |=> ((pmu_ien & $past(bus_wdata[NCORES-1:0])) == '0));

endmodule

bind core_irq_router core_irq_router_chk #(
  .NCORES(NCORES), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CIDX_W(CIDX_W)
) u_chk (
  .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .irq(irq), .fiq(fiq), .ip_flat(ip_flat),
  .fp_flat(fp_flat), .shared_route(shared_route), .pmu_ien(pmu_ien)
);

// File: tb/core_irq_router_bench.sv
module core_irq_router_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [15:0] timer_src = '0;
  logic [15:0] mbox_src = '0;
  logic        shared_src = 1'b0;
  logic [3:0]  perf_src = '0;
  logic [3:0]  irq, fiq;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  core_irq_router u_core_irq_router (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .timer_src(timer_src),
    .mbox_src(mbox_src), .shared_src(shared_src), .perf_src(perf_src),
    .irq(irq), .fiq(fiq)
  );

  // {timer ctl, mailbox ctl, timer lines, mailbox lines, irq pend, fiq pend} of core 0
  localparam logic [43:0] VEC [8] = '{
    {8'h0F, 8'h00, 4'h5, 4'hF, 10'h005, 10'h000},
    {8'hF0, 8'h00, 4'h5, 4'h0, 10'h000, 10'h005},
    {8'hFF, 8'h00, 4'hF, 4'h0, 10'h000, 10'h00F},
    {8'h3C, 8'h00, 4'hF, 4'h0, 10'h00C, 10'h003},
    {8'h00, 8'h0F, 4'hF, 4'hA, 10'h0A0, 10'h000},
    {8'h00, 8'h90, 4'h0, 4'hF, 10'h000, 10'h090},
    {8'h01, 8'h21, 4'h1, 4'h3, 10'h011, 10'h020},
    {8'hFF, 8'hFF, 4'h0, 4'h0, 10'h000, 10'h000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    #1 bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b0; bus_addr = a;
    @(posedge clk);
    #1 d = bus_rdata;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;

    // R1 reset state
    chk("R1 irq", 32'(irq), 32'h0);
    chk("R1 fiq", 32'(fiq), 32'h0);
    rd(8'h0C, d); chk("R1 route", d, 32'h0);
    rd(8'h10, d); chk("R1 pmu mask", d, 32'h0);
    rd(8'h4C, d); chk("R1 timer ctl core3", d, 32'h0);
    rd(8'h50, d); chk("R1 mbox ctl core0", d, 32'h0);

    // table walk on core 0: R2 R3 R4 R5 R6
    for (int i = 0; i < 8; i++) begin
      wr(8'h40, 32'(VEC[i][43:36]));
      wr(8'h50, 32'(VEC[i][35:28]));
      @(negedge clk);
      timer_src[3:0] = VEC[i][27:24];
      mbox_src[3:0]  = VEC[i][23:20];
      rd(8'h60, d); chk("R2/R4 irq pend", d, 32'(VEC[i][19:10]));
      rd(8'h70, d); chk("R3 fiq pend", d, 32'(VEC[i][9:0]));
      chk("R6 irq0", 32'(irq[0]), 32'(|VEC[i][19:10]));
      chk("R6 fiq0", 32'(fiq[0]), 32'(|VEC[i][9:0]));
    end
    @(negedge clk);
    timer_src = '0; mbox_src = '0;

    // R2 per-core word spacing
    wr(8'h44, 32'hFFFF_FF01);
    rd(8'h44, d); chk("R2 ctl readback core1", d, 32'h01);
    @(negedge clk); timer_src[4] = 1'b1;
    rd(8'h64, d); chk("R2 core1 timer0 pend", d, 32'h001);
    chk("R2 irq core1 only", 32'(irq), 32'h2);

    // R6 output lag of one edge
    @(negedge clk); timer_src[4] = 1'b0;
    #1 chk("R6 irq held before edge", 32'(irq[1]), 32'h1);
    @(posedge clk); #1 chk("R6 irq drops after edge", 32'(irq[1]), 32'h0);

    // R4 last core mailbox as FIQ
    wr(8'h5C, 32'h80);
    @(negedge clk); mbox_src[15] = 1'b1;
    rd(8'h7C, d); chk("R4 core3 mbox3 fiq pend", d, 32'h080);
    chk("R4 fiq core3", 32'(fiq), 32'h8);
    @(negedge clk); mbox_src = '0;
    rd(8'h7C, d); chk("R5 level drop", d, 32'h0);

    // R5 pending words ignore writes
    @(negedge clk); timer_src[4] = 1'b1;
    wr(8'h64, 32'h0);
    wr(8'h60, 32'hFFFF);
    rd(8'h64, d); chk("R5 write to pend ignored", d, 32'h001);
    rd(8'h60, d); chk("R5 pend core0 unchanged", d, 32'h0);
    @(negedge clk); timer_src = '0;

    // R7 shared routing
    wr(8'h0C, 32'hE);
    @(negedge clk); shared_src = 1'b1;
    rd(8'h68, d); chk("R7 shared irq core2", d, 32'h100);
    rd(8'h7C, d); chk("R7 shared fiq core3", d, 32'h100);
    chk("R7 irq vector", 32'(irq), 32'h4);
    chk("R7 fiq vector", 32'(fiq), 32'h8);
    wr(8'h0C, 32'hFFFF_FFF5);
    rd(8'h0C, d); chk("R7 route readback", d, 32'h5);
    rd(8'h64, d); chk("R7 same core no irq", d, 32'h0);
    rd(8'h74, d); chk("R7 same core fiq", d, 32'h100);
    @(negedge clk); shared_src = 1'b0;
    rd(8'h74, d); chk("R5 shared level drop", d, 32'h0);

    // R8 performance-monitor set and clear
    wr(8'h10, 32'h05);
    wr(8'h14, 32'h01);
    wr(8'h10, 32'h00);
    rd(8'h10, d); chk("R8 mask after set/clr", d, 32'h04);
    rd(8'h14, d); chk("R8 mask at clr offset", d, 32'h04);
    @(negedge clk); perf_src = 4'hF;
    rd(8'h68, d); chk("R8 perf irq core2", d, 32'h200);
    chk("R8 irq vector", 32'(irq), 32'h4);
    wr(8'h10, 32'h40);
    rd(8'h68, d); chk("R3 perf fiq wins", d, 32'h0);
    rd(8'h78, d); chk("R8 perf fiq core2", d, 32'h200);
    wr(8'h14, 32'h00);
    rd(8'h10, d); chk("R8 zero clear no effect", d, 32'h44);
    wr(8'h14, 32'hFF);
    rd(8'h10, d); chk("R8 clear all", d, 32'h0);
    @(negedge clk); perf_src = '0;

    // R9 undefined offsets
    rd(8'h20, d); chk("R9 undefined 0x20", d, 32'h0);
    rd(8'h80, d); chk("R9 undefined 0x80", d, 32'h0);
    rd(8'h42, d); chk("R9 unaligned 0x42", d, 32'h0);

    finish_run();
  end

endmodule